// File: doc/BRIEF.md
# Mode-0 Programmable Parallel Port

This block is a byte-wide peripheral that sits on a simple strobed register bus. It offers three 8-bit line groups, called port A, port B and port C, plus one control location. Every line can be used as a plain input or as a plain output. Direction is chosen per group: port A and port B each move as a whole byte. Port C is split into an upper and a lower nibble, and each nibble has its own direction. There is no handshaking or interrupt logic; only the basic mode is present.

Software first writes a control word with its top bit set. That word fixes the four directions and clears every output latch. After that, byte writes to the port locations load the output latches. Reads return the live level of each line. A control word with its top bit clear does a different job: it sets or clears one port C line without a read-modify-write.

On the pin side, each line has an output value, an output enable and a sampled input. These are meant to drive a tri-state pad outside the block.

Top module: `par_port_m0`

## Requirements
- R1: During and after reset, every line is an input (`pinOe` all 0), every output latch is 0, `rdData` is 0, and the control readback is 0x9B.
- R2: A write to address 3 is a mode word when bit 7 is 1 and bits 6, 5 and 2 are all 0. A mode word loads four direction bits: bit 4 for port A, bit 1 for port B, bit 3 for port C lines 7..4 and bit 0 for port C lines 3..0. A direction bit of 1 means input. A mode word also clears all 24 output latches to 0 on the next cycle.
- R3: A write to address 3 with bit 7 set and any of bits 6, 5 or 2 set is ignored. Directions, latches and `pinOut` stay unchanged.
- R4: `pinOe` of every line is the inverse of its governing direction bit. Lines 0..7 follow port A, lines 8..15 follow port B, lines 20..23 follow the upper port C bit and lines 16..19 follow the lower port C bit.
- R5: A write to address 0, 1 or 2 loads that port's output latch, which drives lines 8*addr..8*addr+7 of `pinOut` from the next cycle. The write has this effect whether the port is an input or an output, and it never changes `pinOe`.
- R6: A read strobe captures one byte into `rdData` on the clock edge, and `rdData` holds between strobes. For addresses 0..2, each bit is taken from `pinIn` for an input line and from the output latch for an output line.
- R7: A write to address 3 with bit 7 clear sets port C line `wrData[3:1]` to the value `wrData[0]`. Directions and the other latches stay unchanged.
- R8: A read of address 3 returns bit 7 = 1, the four direction bits in their control positions (bits 4, 3, 1 and 0), and 0 in bits 6, 5 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Registered read data |
| pinIn | input | 24 | Sampled line levels, port A in bits 7..0 |
| pinOut | output | 24 | Output latch values |
| pinOe | output | 24 | Output enable per line, 1 = drive |

## Verification
The checker watches several rules on every clock:
- output enables stay grouped by byte and by port C nibble;
- a valid mode word zeroes `pinOut`;
- a malformed mode word or a single-bit command leaves `pinOe` untouched;
- a port write lands in the matching `pinOut` byte;
- `rdData` holds between strobes.

Some behaviour needs the bench's scenarios:
- which control bit governs which group of lines;
- the mix of pin and latch values in a read of a half-input port C;
- the control readback;
- single-line targeting by index.

For these, the bench compares the design against its cycle-by-cycle model.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_PORTS = 3;
  localparam int LINE_CNT  = BYTE_W * NUM_PORTS;
  localparam int NIB_W     = BYTE_W / 2;
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam int PORT_C    = 2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // control word bit positions (decoded by software, so fixed)
  localparam int CW_FLAG   = 7;
  localparam int CW_DIR_A  = 4;
  localparam int CW_DIR_CU = 3;
  localparam int CW_DIR_B  = 1;
  localparam int CW_DIR_CL = 0;
  localparam int CW_MSEL_0 = 2;
  localparam int CW_MSEL_1 = 5;
  localparam int CW_MSEL_2 = 6;

  typedef struct packed {
    logic dirA;
    logic dirB;
    logic dirCu;
    logic dirCl;
  } ppiDir_t;

  localparam ppiDir_t DIR_RESET = '{dirA: 1'b1, dirB: 1'b1, dirCu: 1'b1, dirCl: 1'b1};

  typedef struct packed {
    logic                 modeLoad;
    ppiDir_t              dirNew;
    logic                 bitOp;
    logic [IDX_W-1:0]     bitIdx;
    logic                 bitVal;
    logic [NUM_PORTS-1:0] portWr;
    logic                 rdStb;
    logic [1:0]           rdSel;
  } ppiStrobe_t;
endpackage

// File: rtl/ppi_ctrl.sv
`timescale 1ns/1ps
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output ppiStrobe_t        stb
);
  logic isCtrl;
  logic modeSelZero;

  assign isCtrl      = (addr == ADDR_CTRL);
  assign modeSelZero = ~(wrData[CW_MSEL_0] | wrData[CW_MSEL_1] | wrData[CW_MSEL_2]);

  always_comb begin
    stb = '0;
    stb.modeLoad     = wrEn && isCtrl && wrData[CW_FLAG] && modeSelZero;
    stb.dirNew.dirA  = wrData[CW_DIR_A];
    stb.dirNew.dirB  = wrData[CW_DIR_B];
    stb.dirNew.dirCu = wrData[CW_DIR_CU];
    stb.dirNew.dirCl = wrData[CW_DIR_CL];
    stb.bitOp        = wrEn && isCtrl && !wrData[CW_FLAG];
    stb.bitIdx       = wrData[IDX_W:1];
    stb.bitVal       = wrData[0];
    for (int p = 0; p < NUM_PORTS; p++) begin
      stb.portWr[p] = wrEn && (addr == 2'(p));
    end
    stb.rdStb = rdEn;
    stb.rdSel = addr;
  end
endmodule

// File: rtl/ppi_datapath.sv
`timescale 1ns/1ps
module ppi_datapath
  import ppi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ppiStrobe_t          stb,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [LINE_CNT-1:0] pinIn,
  output logic [LINE_CNT-1:0] pinOut,
  output logic [LINE_CNT-1:0] pinOe,
  output logic [BYTE_W-1:0]   rdData
);
  ppiDir_t                                dirQ;
  logic [NUM_PORTS-1:0][BYTE_W-1:0]       latQ;
  logic [LINE_CNT-1:0]                    lineIsIn;
  logic [LINE_CNT-1:0]                    latFlat;
  logic [LINE_CNT-1:0]                    lineVal;
  logic [BYTE_W-1:0]                      ctrlView;

  always_ff @(posedge clk) begin
    if (!rstN)             dirQ <= DIR_RESET;
    else if (stb.modeLoad) dirQ <= stb.dirNew;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == PORT_C) begin : g_withBit
      always_ff @(posedge clk) begin
        if (!rstN)                latQ[p] <= '0;
        else if (stb.modeLoad)    latQ[p] <= '0;
        else if (stb.portWr[p])   latQ[p] <= wrData;
        else if (stb.bitOp)       latQ[p][stb.bitIdx] <= stb.bitVal;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                latQ[p] <= '0;
        else if (stb.modeLoad)    latQ[p] <= '0;
        else if (stb.portWr[p])   latQ[p] <= wrData;
      end
    end
  end

  for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
    localparam int PIDX = l / BYTE_W;
    localparam int BIDX = l % BYTE_W;
    if (PIDX == 0) begin : g_a
      assign lineIsIn[l] = dirQ.dirA;
    end else if (PIDX == 1) begin : g_b
      assign lineIsIn[l] = dirQ.dirB;
    end else if (BIDX >= NIB_W) begin : g_cu
      assign lineIsIn[l] = dirQ.dirCu;
    end else begin : g_cl
      assign lineIsIn[l] = dirQ.dirCl;
    end
  end

  assign latFlat = latQ;
  assign pinOut  = latFlat;
  assign pinOe   = ~lineIsIn;
  assign lineVal = (lineIsIn & pinIn) | (~lineIsIn & latFlat);

  always_comb begin
    ctrlView = '0;
    ctrlView[CW_FLAG]   = 1'b1;
    ctrlView[CW_DIR_A]  = dirQ.dirA;
    ctrlView[CW_DIR_CU] = dirQ.dirCu;
    ctrlView[CW_DIR_B]  = dirQ.dirB;
    ctrlView[CW_DIR_CL] = dirQ.dirCl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStb) begin
      if (stb.rdSel == ADDR_CTRL) rdData <= ctrlView;
      else                        rdData <= lineVal[stb.rdSel*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/par_port_m0.sv
`timescale 1ns/1ps
module par_port_m0
  import ppi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          addr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  output logic [BYTE_W-1:0]   rdData,
  input  logic [LINE_CNT-1:0] pinIn,
  output logic [LINE_CNT-1:0] pinOut,
  output logic [LINE_CNT-1:0] pinOe
);
  ppiStrobe_t stb;

  ppi_ctrl u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  ppi_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData)
  );
endmodule

// File: rtl/ppi_port_checker.sv
`timescale 1ns/1ps
module ppi_port_checker
  import ppi_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          addr,
  input logic [BYTE_W-1:0]   wrData,
  input logic                wrEn,
  input logic                rdEn,
  input logic [BYTE_W-1:0]   rdData,
  input logic [LINE_CNT-1:0] pinOut,
  input logic [LINE_CNT-1:0] pinOe
);
  logic ctrlWr;
  logic goodMode;
  logic badMode;
  assign ctrlWr   = wrEn && (addr == ADDR_CTRL);
  assign goodMode = ctrlWr && wrData[7] && !wrData[6] && !wrData[5] && !wrData[2];
  assign badMode  = ctrlWr && wrData[7] && (wrData[6] || wrData[5] || wrData[2]);

  assert_oe_grouped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe[7:0] == 8'h00 || pinOe[7:0] == 8'hFF) &&
    (pinOe[15:8] == 8'h00 || pinOe[15:8] == 8'hFF) &&
    (pinOe[19:16] == 4'h0 || pinOe[19:16] == 4'hF) &&
    (pinOe[23:20] == 4'h0 || pinOe[23:20] == 4'hF));

  assert_mode_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    goodMode |=> (pinOut == '0));

  assert_bad_mode_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    badMode |=> ($stable(pinOe) && $stable(pinOut)));

  assert_bitop_keeps_dir_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[7]) |=> $stable(pinOe));

  assert_port_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != ADDR_CTRL) |=> $stable(pinOe) &&
      (pinOut[$past(addr)*BYTE_W +: BYTE_W] == $past(wrData)));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind par_port_m0 ppi_port_checker u_chk (.*);

// File: tb/test_par_port_m0.sv
`timescale 1ns/1ps
module test_par_port_m0;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [23:0] pinIn = '0;
  logic [23:0] pinOut;
  logic [23:0] pinOe;

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  par_port_m0 i_par_port_m0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always #10 clk = ~clk;

  // behavioural reference
  bit         mA, mB, mCu, mCl;
  logic [7:0] mlat [3];
  logic [7:0] mrd;

  function automatic bit lineIn(int l);
    if (l < 8)  return mA;
    if (l < 16) return mB;
    if (l < 20) return mCl;
    return mCu;
  endfunction

  function automatic logic [23:0] expOe();
    logic [23:0] v;
    for (int l = 0; l < 24; l++) v[l] = !lineIn(l);
    return v;
  endfunction

  function automatic logic [7:0] readModel(logic [1:0] a);
    logic [7:0] v;
    if (a == 2'd3) return {1'b1, 2'b00, mA, mCu, 1'b0, mB, mCl};
    for (int b = 0; b < 8; b++) begin
      int line = int'(a) * 8 + b;
      v[b] = lineIn(line) ? pinIn[line] : mlat[a][b];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mA = 1; mB = 1; mCu = 1; mCl = 1;
      for (int p = 0; p < 3; p++) mlat[p] = 8'h00;
      mrd = 8'h00;
    end else begin
      if (rdEn) mrd = readModel(addr);
      if (wrEn) begin
        if (addr != 2'd3) mlat[addr] = wrData;
        else if (wrData[7]) begin
          if (!wrData[6] && !wrData[5] && !wrData[2]) begin
            mA = wrData[4]; mCu = wrData[3]; mB = wrData[1]; mCl = wrData[0];
            for (int p = 0; p < 3; p++) mlat[p] = 8'h00;
          end
        end else mlat[2][wrData[3:1]] = wrData[0];
      end
    end
  end

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !over) begin
      chk("R5", "pinOut vs model", pinOut, {mlat[2], mlat[1], mlat[0]});
      chk("R4", "pinOe vs model", pinOe, expOe());
      chk("R6", "rdData vs model", {16'h0, rdData}, {16'h0, mrd});
    end
  end

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic summary();
    over = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", pinOe, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "oe after reset", pinOe, 24'h0);
    chk("R1", "out after reset", pinOut, 24'h0);
    chk("R1", "rdData after reset", {16'h0, rdData}, 24'h0);
    busRead(2'd3, v);
    chk("R8", "reset control view", {16'h0, v}, 24'h00009B);

    pinIn = 24'h123456;
    busRead(2'd0, v);
    chk("R6", "read A input", {16'h0, v}, 24'h000056);
    busRead(2'd2, v);
    chk("R6", "read C input", {16'h0, v}, 24'h000012);

    busWrite(2'd0, 8'h5A);
    chk("R5", "latch while input", pinOut, 24'h00005A);
    chk("R5", "oe untouched", pinOe, 24'h0);

    busWrite(2'd3, 8'h80);
    chk("R2", "all outputs oe", pinOe, 24'hFFFFFF);
    chk("R2", "latches cleared", pinOut, 24'h0);
    busRead(2'd3, v);
    chk("R8", "control view 80", {16'h0, v}, 24'h000080);

    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h7E);
    chk("R5", "three latches", pinOut, 24'h7EC35A);
    pinIn = 24'hFFFFFF;
    busRead(2'd0, v);
    chk("R6", "read A output returns latch", {16'h0, v}, 24'h00005A);

    busWrite(2'd3, 8'h84);
    chk("R3", "bit2 mode ignored oe", pinOe, 24'hFFFFFF);
    chk("R3", "bit2 mode ignored out", pinOut, 24'h7EC35A);
    busWrite(2'd3, 8'hB1);
    chk("R3", "bit5 mode ignored oe", pinOe, 24'hFFFFFF);
    busWrite(2'd3, 8'hC0);
    chk("R3", "bit6 mode ignored out", pinOut, 24'h7EC35A);

    busWrite(2'd3, 8'h0F);
    chk("R7", "set C line7", {16'h0, pinOut[23:16]}, 24'h0000FE);
    busWrite(2'd3, 8'h08);
    chk("R7", "clear C line4", {16'h0, pinOut[23:16]}, 24'h0000EE);
    chk("R7", "dirs unchanged", pinOe, 24'hFFFFFF);
    chk("R7", "other latches unchanged", {8'h0, pinOut[15:0]}, 24'h00C35A);

    busWrite(2'd3, 8'h91);
    chk("R4", "A in, Cl in", pinOe, 24'hF0FF00);
    chk("R2", "cleared again", pinOut, 24'h0);
    busWrite(2'd2, 8'h7E);
    pinIn = 24'hA5993C;
    busRead(2'd2, v);
    chk("R6", "C mixed read", {16'h0, v}, 24'h000075);
    busRead(2'd0, v);
    chk("R6", "A input read", {16'h0, v}, 24'h00003C);
    busRead(2'd1, v);
    chk("R6", "B output read", {16'h0, v}, 24'h000000);
    busWrite(2'd0, 8'hC3);
    chk("R5", "A input latch", {16'h0, pinOut[7:0]}, 24'h0000C3);
    chk("R5", "A input oe stays 0", {16'h0, pinOe[7:0]}, 24'h0);

    busWrite(2'd3, 8'h8A);
    chk("R4", "A out B in Cu in Cl out", pinOe, 24'h0F00FF);
    busRead(2'd3, v);
    chk("R8", "control view 8A", {16'h0, v}, 24'h00008A);
    busWrite(2'd3, 8'h0B);
    chk("R7", "set C line5 while Cu input", {16'h0, pinOut[23:16]}, 24'h000020);
    chk("R7", "oe after bit op", pinOe, 24'h0F00FF);
    repeat (3) @(negedge clk);
    chk("R6", "rdData holds", {16'h0, rdData}, 24'h00008A);

    summary();
    $finish;
  end
endmodule